// File: doc/BRIEF.md
# Multiplexed-Bus Two-Register Slave

This block is a bus slave for a 16-bit multiplexed address/data bus whose lines are active low, so the wires carry the bitwise complement of every logical address and data word. A master starts a transfer by lowering a frame strobe while the address is on the bus. It then either replaces the address with write data and lowers a write strobe, or floats the bus and lowers a read strobe. The slave answers with an active-low reply line. The slave decodes two word registers: a control/status word and a data word. The host paces data transfers by polling a ready flag in the status word.

All bus inputs pass through a two-flop synchronizer, and a six-state machine runs the handshake. **ST_IDLE** waits for the synchronized frame strobe to fall and latches the address. It moves to **ST_ADDR** on a decode hit, or to **ST_MISS** otherwise. **ST_MISS** stays silent until the frame strobe rises, then returns to ST_IDLE. **ST_ADDR** has three exits:
- It performs the write and moves to **ST_WREPLY** when the write strobe is seen.
- It latches the read word and moves to **ST_RDRIVE** when the read strobe is seen.
- It returns to ST_IDLE if the frame is abandoned.

**ST_WREPLY** holds the reply low until the frame and write strobes are both high, then returns to ST_IDLE. **ST_RDRIVE** drives the bus for one cycle with the reply still high, then moves to **ST_RREPLY**. **ST_RREPLY** holds the bus and the reply until the frame and read strobes are both high, then returns to ST_IDLE.

A one-cycle strobe from the logic behind the data register loads a fresh word and sets the ready flag. Any read or write of the data register through the bus clears the flag.

Top module: `mux_bus_slave`

## Requirements
- R1: While `init_n` is low, `rply_n` is high, `bus_oe` is low, and `ctrl_o`, `data_o` and the ready flag are zero.
- R2: A bus write to the status address (logical 16'o177130) stores the written word masked by 16'hFF7F into `ctrl_o`. A later read of that address returns that stored word with bit 7 replaced by the ready flag.
- R3: Bus values are complemented: the logical word written is `~bus_ad_i`, and a read drives `bus_ad_o` equal to `~word`. `bus_ad_o` stays stable while `bus_oe` is high.
- R4: In a write cycle, `rply_n` falls only after the write strobe has been low. It rises only after the frame and write strobes are both high, at least two cycles after their release.
- R5: In a read cycle, `bus_oe` rises one cycle before `rply_n` falls. Both stay asserted until the frame and read strobes are both high, after which `rply_n` rises and `bus_oe` falls.
- R6: A frame at any address other than 16'o177130 and 16'o177132 (including odd addresses) gets no reply and no bus drive, and changes no register.
- R7: A one-cycle `data_ready_stb` loads `data_ready_word` into the data register and sets the ready flag (status bit 7) in the next cycle.
- R8: A bus read or write of the data address (16'o177132) clears the ready flag. A write also stores the word in `data_o`, and a read returns the data register.
- R9: Status bit 7 is not writable: writing 1 there does not set the ready flag, and a status write does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| init_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Active-low frame strobe; address valid on its fall |
| din_n | input | 1 | Active-low read strobe |
| dout_n | input | 1 | Active-low write strobe |
| bus_ad_i | input | 16 | Bus lines as seen by the slave (complemented) |
| bus_ad_o | output | 16 | Complemented read word to drive onto the bus |
| bus_oe | output | 1 | Bus drive enable for the tri-state buffer |
| rply_n | output | 1 | Active-low reply |
| data_ready_stb | input | 1 | Internal strobe: new data word ready |
| data_ready_word | input | 16 | Word loaded into the data register on the strobe |
| ctrl_o | output | 16 | Stored control bits |
| data_o | output | 16 | Current data register |

## Verification
The assertions rely on a well-behaved master. It lowers the frame strobe with the address already on the bus. It changes to write data before lowering the write strobe. It holds its strobes low until it sees the reply, and it never lowers the read and write strobes in the same frame. The bench master waits several cycles between each phase change and after every reply release, so every step is seen after synchronization. The ready strobe is pulsed only between frames.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MISS,
        ST_ADDR,
        ST_WREPLY,
        ST_RDRIVE,
        ST_RREPLY
    } mbs_state_e;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         init_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/mbs_decode.sv
module mbs_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] CSR_ADDR  = 16'o177130,
    parameter logic [AW-1:0] DATA_ADDR = 16'o177132
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic          sel_data
);
    logic hit_csr;
    logic hit_data;

    assign hit_csr  = (addr == CSR_ADDR);
    assign hit_data = (addr == DATA_ADDR);
    assign hit      = hit_csr | hit_data;
    assign sel_data = hit_data;
endmodule

// File: rtl/mbs_regs.sv
module mbs_regs #(
    parameter int DW = 16,
    parameter int RDY_BIT = 7,
    parameter logic [DW-1:0] CSR_WMASK = 16'hFF7F
) (
    input  logic          clk,
    input  logic          init_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          sel_data,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_word,
    input  logic          stb,
    input  logic [DW-1:0] stb_word,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] data_o,
    output logic          ready_o
);
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] data_q;
    logic          ready_q;
    logic          data_touch;
    logic [DW-1:0] csr_view;

    assign data_touch = (wr_en | rd_en) & sel_data;

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            ctrl_q  <= '0;
            data_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            if (wr_en && !sel_data) ctrl_q <= wr_word & CSR_WMASK;
            if (stb)                     data_q <= stb_word;
            else if (wr_en && sel_data)  data_q <= wr_word;
            if (stb)             ready_q <= 1'b1;
            else if (data_touch) ready_q <= 1'b0;
        end
    end

    always_comb begin
        csr_view          = ctrl_q;
        csr_view[RDY_BIT] = ready_q;
    end

    assign rd_word = sel_data ? data_q : csr_view;
    assign ctrl_o  = ctrl_q;
    assign data_o  = data_q;
    assign ready_o = ready_q;
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
    import mbs_pkg::*;
#(
    parameter int DW = 16,
    parameter int SYNC_STAGES = 2,
    parameter int RDY_BIT = 7,
    parameter logic [DW-1:0] CSR_ADDR  = 16'o177130,
    parameter logic [DW-1:0] DATA_ADDR = 16'o177132,
    parameter logic [DW-1:0] CSR_WMASK = 16'hFF7F
) (
    input  logic          clk,
    input  logic          init_n,
    input  logic          sync_n,
    input  logic          din_n,
    input  logic          dout_n,
    input  logic [DW-1:0] bus_ad_i,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_oe,
    output logic          rply_n,
    input  logic          data_ready_stb,
    input  logic [DW-1:0] data_ready_word,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] data_o
);
    localparam int SW = DW + 3;

    logic [SW-1:0] raw_in;
    logic [SW-1:0] syn_in;
    logic          s_sync_n, s_din_n, s_dout_n;
    logic [DW-1:0] s_ad;
    logic          sync_d;
    logic          sync_fall;

    mbs_state_e state, nxt;

    logic          dec_hit, dec_sel;
    logic          hit_q, sel_q;
    logic          wr_en, rd_en;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] rd_q;
    logic          ready_w;

    assign raw_in = {sync_n, din_n, dout_n, bus_ad_i};

    mbs_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .init_n(init_n), .d(raw_in), .q(syn_in)
    );

    assign {s_sync_n, s_din_n, s_dout_n, s_ad} = syn_in;
    assign sync_fall = sync_d & ~s_sync_n;

    mbs_decode #(.AW(DW), .CSR_ADDR(CSR_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
        .addr(~s_ad), .hit(dec_hit), .sel_data(dec_sel)
    );

    assign wr_en = (state == ST_ADDR) & ~s_sync_n & ~s_dout_n;
    assign rd_en = (state == ST_ADDR) & ~s_sync_n & s_dout_n & ~s_din_n;

    mbs_regs #(.DW(DW), .RDY_BIT(RDY_BIT), .CSR_WMASK(CSR_WMASK)) u_regs (
        .clk(clk), .init_n(init_n),
        .wr_en(wr_en), .rd_en(rd_en), .sel_data(sel_q),
        .wr_word(~s_ad), .rd_word(rd_word),
        .stb(data_ready_stb), .stb_word(data_ready_word),
        .ctrl_o(ctrl_o), .data_o(data_o), .ready_o(ready_w)
    );

    // State register
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) state <= ST_IDLE;
        else         state <= nxt;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (sync_fall) nxt = dec_hit ? ST_ADDR : ST_MISS;
            ST_MISS:   if (s_sync_n) nxt = ST_IDLE;
            ST_ADDR: begin
                if (s_sync_n)      nxt = ST_IDLE;
                else if (!s_dout_n) nxt = ST_WREPLY;
                else if (!s_din_n)  nxt = ST_RDRIVE;
            end
            ST_WREPLY: if (s_sync_n && s_dout_n) nxt = ST_IDLE;
            ST_RDRIVE: nxt = ST_RREPLY;
            ST_RREPLY: if (s_sync_n && s_din_n) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Frame capture and read word latch
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            sync_d <= 1'b1;
            hit_q  <= 1'b0;
            sel_q  <= 1'b0;
            rd_q   <= '0;
        end else begin
            sync_d <= s_sync_n;
            if (state == ST_IDLE && sync_fall) begin
                hit_q <= dec_hit;
                sel_q <= dec_sel;
            end
            if (rd_en) rd_q <= rd_word;
        end
    end

    // Outputs decoded from state
    always_comb begin
        rply_n   = 1'b1;
        bus_oe   = 1'b0;
        bus_ad_o = ~rd_q;
        unique case (state)
            ST_WREPLY: rply_n = 1'b0;
            ST_RDRIVE: bus_oe = 1'b1;
            ST_RREPLY: begin
                bus_oe = 1'b1;
                rply_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          init_n,
    input logic          sync_n,
    input logic          din_n,
    input logic          dout_n,
    input logic          rply_n,
    input logic          bus_oe,
    input logic [DW-1:0] bus_ad_o,
    input logic          stb,
    input logic          ready,
    input logic          hit
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !init_n |-> (rply_n && !bus_oe && !ready)); // R1

    AST_STABLE_DRIVE: assert property (@(posedge clk) disable iff (!init_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_ad_o)); // R3

    AST_REPLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!init_n)
        $fell(rply_n) |-> ($past(!din_n) || $past(!dout_n))); // R4

    AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!init_n)
        $rose(rply_n) |-> $past(sync_n && din_n && dout_n)); // R4

    AST_DRIVE_BEFORE_REPLY: assert property (@(posedge clk) disable iff (!init_n)
        $rose(bus_oe) |-> (rply_n && $past(!din_n))); // R5

    AST_REPLY_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!init_n)
        $fell(rply_n) |-> hit); // R6

    AST_READY_AFTER_STB: assert property (@(posedge clk) disable iff (!init_n)
        stb |=> ready); // R7
endmodule

bind mux_bus_slave mbs_checker #(.DW(DW)) u_mbs_checker (
    .clk(clk), .init_n(init_n), .sync_n(sync_n), .din_n(din_n), .dout_n(dout_n),
    .rply_n(rply_n), .bus_oe(bus_oe), .bus_ad_o(bus_ad_o),
    .stb(data_ready_stb), .ready(ready_w), .hit(hit_q)
);

// File: tb/tb_mux_bus_slave.sv
`timescale 1ns/1ps
module tb_mux_bus_slave;
    localparam logic [15:0] A_CSR  = 16'o177130;
    localparam logic [15:0] A_DATA = 16'o177132;
    localparam logic [15:0] WMASK  = 16'hFF7F;

    logic        clk = 1'b0;
    logic        init_n, sync_n, din_n, dout_n, stb;
    logic [15:0] ad_m, stb_word;
    logic [15:0] bus_ad_o, ctrl_o, data_o;
    logic        bus_oe, rply_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mux_bus_slave dut (
        .clk(clk), .init_n(init_n), .sync_n(sync_n), .din_n(din_n), .dout_n(dout_n),
        .bus_ad_i(ad_m), .bus_ad_o(bus_ad_o), .bus_oe(bus_oe), .rply_n(rply_n),
        .data_ready_stb(stb), .data_ready_word(stb_word),
        .ctrl_o(ctrl_o), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit want, input string tag);
        bit early = 0;
        bit got = 0;
        int rel = 0;
        @(negedge clk) ad_m = ~a;
        @(negedge clk) sync_n = 1'b0;
        repeat (3) @(negedge clk) if (!rply_n || bus_oe) early = 1;
        ad_m = ~d;
        repeat (3) @(negedge clk) if (!rply_n || bus_oe) early = 1;
        dout_n = 1'b0;
        for (int i = 0; i < 30 && !got; i++) begin
            @(negedge clk);
            if (!rply_n) got = 1;
            if (bus_oe) early = 1;
        end
        chk(got == want, {tag, " reply presence"}, got, want);
        chk(!early, {tag, " no reply or drive before write strobe"}, early, 0);
        sync_n = 1'b1;
        dout_n = 1'b1;
        ad_m = '1;
        if (got) begin
            while (!rply_n && rel < 30) begin
                @(negedge clk);
                rel++;
            end
            // R4: release no sooner than two cycles after the strobes rise
            chk(rel >= 2 && rel < 30, "R4 reply release delay", rel, 2);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] v, input bit want, input string tag);
        bit got = 0;
        bit drove = 0;
        v = '0;
        @(negedge clk) ad_m = ~a;
        @(negedge clk) sync_n = 1'b0;
        repeat (3) @(negedge clk);
        ad_m = '1;
        repeat (2) @(negedge clk);
        din_n = 1'b0;
        for (int i = 0; i < 30 && !got; i++) begin
            @(negedge clk);
            if (bus_oe) drove = 1;
            if (!rply_n) got = 1;
        end
        chk(got == want, {tag, " reply presence"}, got, want);
        if (got) begin
            chk(bus_oe, "R5 bus driven while reply low", bus_oe, 1);
            v = ~bus_ad_o;
        end else begin
            chk(!drove, "R6 no bus drive on miss", drove, 0);
        end
        sync_n = 1'b1;
        din_n = 1'b1;
        for (int i = 0; i < 30 && !rply_n; i++) @(negedge clk);
        chk(rply_n && !bus_oe, "R5 reply and drive released", {rply_n, bus_oe}, 2'b10);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_stb(input logic [15:0] w);
        @(negedge clk);
        stb = 1'b1;
        stb_word = w;
        @(negedge clk);
        stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv, v, ctl, w;
        logic [15:0] miss_addr [5];
        init_n = 1'b0;
        sync_n = 1'b1;
        din_n = 1'b1;
        dout_n = 1'b1;
        stb = 1'b0;
        stb_word = '0;
        ad_m = '1;
        repeat (4) @(negedge clk);
        chk(rply_n && !bus_oe, "R1 reset handshake idle", {rply_n, bus_oe}, 2'b10);
        chk(ctrl_o == 0 && data_o == 0, "R1 reset registers", {ctrl_o, data_o}, 0);
        init_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(A_CSR, rv, 1, "R1");
        chk(rv == 0, "R1 status after reset", rv, 0);

        // R2 / R9: walking one and walking zero through the status word
        for (int i = 0; i < 32; i++) begin
            v = (i < 16) ? (16'h1 << i) : ~(16'h1 << (i - 16));
            bus_write(A_CSR, v, 1, "R2");
            chk(ctrl_o == (v & WMASK), "R2 ctrl_o masked", ctrl_o, v & WMASK);
            bus_read(A_CSR, rv, 1, "R2");
            chk(rv == (v & WMASK), "R9 R2 status readback bit7 stays 0", rv, v & WMASK);
        end
        ctl = (16'hFFFF << 16) | 16'h0000;
        bus_write(A_CSR, 16'h0000, 1, "R2");

        // R3 / R8: walking patterns through the data word
        for (int i = 0; i < 16; i++) begin
            v = (16'h1 << i) ^ (i[0] ? 16'hFFFF : 16'h0000);
            bus_write(A_DATA, v, 1, "R8");
            chk(data_o == v, "R3 write data is complement of bus", data_o, v);
            bus_read(A_DATA, rv, 1, "R3");
            chk(rv == v, "R3 read drives complement", rv, v);
        end

        // R7 / R8 / R9: ready flag sequencing
        for (int k = 0; k < 4; k++) begin
            w = 16'h1357 * (k + 1) ^ 16'h8421;
            pulse_stb(w);
            chk(data_o == w, "R7 strobe loads data", data_o, w);
            bus_read(A_CSR, rv, 1, "R7");
            chk(rv == 16'h0080, "R7 ready set", rv, 16'h0080);
            bus_write(A_CSR, 16'h0000, 1, "R9");
            bus_read(A_CSR, rv, 1, "R9");
            chk(rv == 16'h0080, "R9 status write keeps ready", rv, 16'h0080);
            if (k[0]) begin
                bus_read(A_DATA, rv, 1, "R8");
                chk(rv == w, "R8 data read returns loaded word", rv, w);
            end else begin
                bus_write(A_DATA, ~w, 1, "R8");
                chk(data_o == ~w, "R8 data write stores", data_o, ~w);
            end
            bus_read(A_CSR, rv, 1, "R8");
            chk(rv == 16'h0000, "R8 data access clears ready", rv, 16'h0000);
        end
        bus_write(A_CSR, 16'h0080, 1, "R9");
        bus_read(A_CSR, rv, 1, "R9");
        chk(rv == 16'h0000, "R9 bit7 not writable", rv, 16'h0000);

        // R6: unmapped frames
        miss_addr[0] = 16'o177134;
        miss_addr[1] = 16'o177126;
        miss_addr[2] = 16'o177131;
        miss_addr[3] = 16'h0000;
        miss_addr[4] = 16'hFFFF;
        bus_write(A_CSR, 16'h0F0F, 1, "R2");
        bus_write(A_DATA, 16'h3C3C, 1, "R8");
        for (int j = 0; j < 5; j++) begin
            bus_write(miss_addr[j], 16'hDEAD, 0, "R6");
            chk(ctrl_o == 16'h0F0F && data_o == 16'h3C3C, "R6 miss leaves registers",
                {ctrl_o, data_o}, {16'h0F0F, 16'h3C3C});
            bus_read(miss_addr[j], rv, 0, "R6");
        end
        bus_read(A_DATA, rv, 1, "R6");
        chk(rv == 16'h3C3C, "R6 decode still works after misses", rv, 16'h3C3C);
        if (ctl == 0) ctl = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule